// File: doc/BRIEF.md
# Programmable Filter Clock Divider Chain

This block turns one reference oscillator clock into two slower timing signals: a filter sampling clock and a modulation clock. A programmable counter divides the reference by a value N. A fixed halving stage follows, so the filter clock runs at the reference rate divided by 2N. A further stage counts twenty filter-clock periods per half cycle, so the modulation clock runs at the filter rate divided by 40.

Every stage runs on the reference clock. Each stage passes a one-cycle enable pulse to the next, and each derived clock is also given as a registered square wave. The divider value comes in through a plain write strobe with a 6-bit value, which stands in for a host serial link. After reset the value is 31, which gives a ratio of 62 to the filter clock. A written value takes effect only when the programmable counter next reaches its terminal count, so no output period is ever shortened or stretched to a third length. The value that is in force can be read back on a status output.

Top module: `fdc_clk_chain`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), fclk_ce, fclk_sq, mclk_ce and mclk_sq are 0 and div_active reads 31. The first filter periods then span 62 reference cycles.
- R2: For an active value N in 2..63, fclk_ce is a one-cycle pulse that repeats every 2N reference cycles.
- R3: fclk_sq is a square wave that stays high for N reference cycles and low for N reference cycles.
- R4: mclk_ce is a one-cycle pulse that repeats every 80N reference cycles, which is once per 40 fclk_ce pulses.
- R5: mclk_sq stays high for 40N reference cycles and low for 40N reference cycles.
- R6: A written value of 0 or 1 is replaced by 2. div_active then reads 2 and fclk_ce repeats every 4 cycles.
- R7: A new value takes effect only at the terminal count of the programmable counter. Around a write, every high or low run of fclk_sq lasts either the old N or the new N.
- R8: Written values 29, 30, 31 and 32 give fclk_ce periods of 58, 60, 62 and 64 cycles.
- R9: div_active shows the value in force (after clamping) once the next terminal count has passed.
- R10: Driving rst_n low in the middle of operation clears all outputs and restores the value 31, even after other values have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the divider value |
| cfg_div | input | 6 | Divider value to write |
| fclk_ce | output | 1 | Filter clock enable, one cycle every 2N cycles |
| fclk_sq | output | 1 | Filter clock square wave, registered |
| mclk_ce | output | 1 | Modulation clock enable, one cycle every 80N cycles |
| mclk_sq | output | 1 | Modulation clock square wave, registered |
| div_active | output | 6 | Divider value now in force |

## Verification
The bench writes a new value partway through a filter period and measures every half-period of the square wave that follows. A design that loaded the value at once would produce a runt or stretched run whose length is neither the old N nor the new N. Writes of 0 and 1 check the clamp: without it the counter would stall or wrap to a very long period. The bench measures the modulation clock at both ends of the range, which exposes a terminal count of 19 or 21 in place of 20. Random values from the whole 6-bit range, together with a reset in the middle of a run, expose off-by-one terminal counts and lost defaults.

// File: rtl/fdc_pkg.sv
// Package: types and default settings shared by the filter clock divider chain.
// It assumes that every stage runs in the single reference clock domain.
package fdc_pkg;
    // Output of one fixed stage: an enable pulse and its square wave
    typedef struct packed {
        logic ce;
        logic sq;
    } stage_out_t;

    localparam int FDC_DIV_W       = 6;
    localparam int FDC_DIV_DEFAULT = 31;
    localparam int FDC_DIV_FLOOR   = 2;
    localparam int FDC_MOD_HALF    = 20;
endpackage

// File: rtl/fdc_prescaler.sv
// Module: programmable divide-by-N counter.
// It holds a pending value that the write port sets, clamped to FLOOR.
// The pending value moves to the active value only at terminal count.
// tc is high for one reference cycle every N cycles.
// It assumes FLOOR >= 2 and RST_VAL in FLOOR..2**W-1.
module fdc_prescaler #(
    parameter int W       = 6,
    parameter int RST_VAL = 31,
    parameter int FLOOR   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic         tc,
    output logic [W-1:0] act_val
);
    localparam logic [W-1:0] RST_L   = W'(RST_VAL);
    localparam logic [W-1:0] FLOOR_L = W'(FLOOR);
    localparam logic [W-1:0] ONE_L   = W'(1);

    logic [W-1:0] pend_q;
    logic [W-1:0] act_q;
    logic [W-1:0] cnt_q;

    // Terminal count: the last cycle of the current divide period
    always_comb tc = (cnt_q == act_q - ONE_L);

    // Capture a written value and clamp values below the floor
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= RST_L;
        else if (wr_en)
            pend_q <= (wr_val < FLOOR_L) ? FLOOR_L : wr_val;
    end

    // Move the pending value into use only at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= RST_L;
        else if (tc)
            act_q <= pend_q;
    end

    // Count reference cycles within the divide period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tc)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + ONE_L;
    end

    assign act_val = act_q;

    AST_CNT_BELOW_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q); // R2
    AST_ACT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_q >= FLOOR_L); // R6
    AST_ACT_HOLD_OFF_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(act_q)); // R7
endmodule

// File: rtl/fdc_toggle_div.sv
// Module: fixed divider that counts HALF input enable pulses per half period.
// The square wave toggles once every HALF pulses.
// The output enable fires on the falling edge of the square wave.
// The wave has a 50% duty cycle, and ce fires once every 2*HALF input pulses.
// It assumes that input pulses are at least two cycles apart.
module fdc_toggle_div #(
    parameter int HALF = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_ce,
    output fdc_pkg::stage_out_t out
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] STEP = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          sq_q;
    logic          ce_q;
    logic          wrap;

    // Last input pulse of the current half period
    always_comb wrap = in_ce && (cnt_q == LAST);

    // Count input pulses within the half period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (in_ce)
            cnt_q <= wrap ? '0 : cnt_q + STEP;
    end

    // Toggle the square wave at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n)
            sq_q <= 1'b0;
        else if (wrap)
            sq_q <= ~sq_q;
    end

    // Send an enable pulse as the wave falls, once per full period
    always_ff @(posedge clk) begin
        if (!rst_n)
            ce_q <= 1'b0;
        else
            ce_q <= wrap && sq_q;
    end

    assign out.ce = ce_q;
    assign out.sq = sq_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R4
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_q |=> !ce_q); // R2
    AST_SQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ce |=> $stable(sq_q)); // R3
    AST_CE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ce_q |-> $fell(sq_q)); // R5
endmodule

// File: rtl/fdc_clk_chain.sv
// Module: top of the filter clock divider chain.
// The programmable prescaler feeds a fixed halving stage, which gives the
// filter clock. A generate-built cascade of fixed stages follows; its last
// stage gives the modulation clock. All stages use one clock and a
// synchronous active-low reset.
module fdc_clk_chain #(
    parameter int DIV_W       = fdc_pkg::FDC_DIV_W,
    parameter int DIV_DEFAULT = fdc_pkg::FDC_DIV_DEFAULT,
    parameter int DIV_FLOOR   = fdc_pkg::FDC_DIV_FLOOR,
    parameter int MOD_HALF    = fdc_pkg::FDC_MOD_HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             fclk_ce,
    output logic             fclk_sq,
    output logic             mclk_ce,
    output logic             mclk_sq,
    output logic [DIV_W-1:0] div_active
);
    import fdc_pkg::*;

    localparam int NSTAGE = 2;
    localparam logic [DIV_W-1:0] FLOOR_L = DIV_W'(DIV_FLOOR);

    logic                    tc;
    logic [NSTAGE:0]         stage_in;
    stage_out_t [NSTAGE-1:0] stage_out;

    fdc_prescaler #(
        .W       (DIV_W),
        .RST_VAL (DIV_DEFAULT),
        .FLOOR   (DIV_FLOOR)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_val  (cfg_div),
        .tc      (tc),
        .act_val (div_active)
    );

    assign stage_in[0] = tc;

    // Cascade of fixed stages: halving first, then the modulation divider
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        localparam int H = (s == 0) ? 1 : MOD_HALF;
        fdc_toggle_div #(.HALF(H)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .in_ce (stage_in[s]),
            .out   (stage_out[s])
        );
        assign stage_in[s+1] = stage_out[s].ce;
    end

    assign fclk_ce = stage_out[0].ce;
    assign fclk_sq = stage_out[0].sq;
    assign mclk_ce = stage_out[NSTAGE-1].ce;
    assign mclk_sq = stage_out[NSTAGE-1].sq;

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div_active >= FLOOR_L); // R6
    AST_MCE_WITH_FCE: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_ce |-> $past(fclk_ce)); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!fclk_ce && !fclk_sq && !mclk_ce && !mclk_sq)); // R10
endmodule

// File: tb/sim_fdc_clk_chain.sv
// Bench: directed corner cases plus random divider values from a seeded $urandom.
module sim_fdc_clk_chain;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_div = '0;
    logic       fclk_ce, fclk_sq, mclk_ce, mclk_sq;
    logic [5:0] div_active;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    fdc_clk_chain u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_div    (cfg_div),
        .fclk_ce    (fclk_ce),
        .fclk_sq    (fclk_sq),
        .mclk_ce    (mclk_ce),
        .mclk_sq    (mclk_sq),
        .div_active (div_active)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 180000) begin
            total++; bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 180000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int exp_n(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_div = 6'(v);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic wait_fce();
        do @(negedge clk); while (!fclk_ce);
    endtask

    task automatic wait_mce();
        do @(negedge clk); while (!mclk_ce);
    endtask

    task automatic fce_period(output int p);
        wait_fce();
        p = 0;
        do begin @(negedge clk); p++; end while (!fclk_ce);
    endtask

    task automatic mce_period(output int p);
        wait_mce();
        p = 0;
        do begin @(negedge clk); p++; end while (!mclk_ce);
    endtask

    // Length of the next complete high run of fclk_sq
    task automatic fsq_high(output int p);
        do @(negedge clk); while (fclk_sq);
        do @(negedge clk); while (!fclk_sq);
        p = 0;
        do begin @(negedge clk); p++; end while (fclk_sq);
    endtask

    task automatic msq_high(output int p);
        do @(negedge clk); while (mclk_sq);
        do @(negedge clk); while (!mclk_sq);
        p = 0;
        do begin @(negedge clk); p++; end while (mclk_sq);
    endtask

    // Length of the next complete run of fclk_sq at either level
    task automatic fsq_run(output int p);
        logic lvl;
        lvl = fclk_sq;
        do @(negedge clk); while (fclk_sq == lvl);
        lvl = fclk_sq;
        p = 0;
        do begin @(negedge clk); p++; end while (fclk_sq == lvl);
    endtask

    initial begin
        int p;
        int v;
        int n;
        void'($urandom(32'h5EED_0031));

        // R1: outputs and value while reset is held
        repeat (3) @(negedge clk);
        chk(!fclk_ce && !fclk_sq && !mclk_ce && !mclk_sq, "R1 outputs in reset",
            {fclk_ce, fclk_sq, mclk_ce, mclk_sq}, 0);
        chk(div_active == 6'd31, "R1 default value", div_active, 31);
        rst_n = 1'b1;
        fce_period(p);
        chk(p == 62, "R1 default fclk_ce period", p, 62);

        // R3: duty cycle at the default value
        fsq_high(p);
        chk(p == 31, "R3 fclk_sq high at 31", p, 31);
        fsq_run(p);
        chk(p == 31, "R3 fclk_sq run at 31", p, 31);

        // R4, R5: modulation clock at the default value
        mce_period(p);
        chk(p == 80 * 31, "R4 mclk_ce period at 31", p, 80 * 31);
        msq_high(p);
        chk(p == 40 * 31, "R5 mclk_sq high at 31", p, 40 * 31);

        // R8: directed values around the default
        for (int k = 29; k <= 32; k++) begin
            write_div(k);
            repeat (2) wait_fce();
            fce_period(p);
            chk(p == 2 * k, "R8 fclk_ce period", p, 2 * k);
        end

        // R6: values below the floor are clamped to 2
        for (int k = 0; k < 2; k++) begin
            write_div(k);
            repeat (2) wait_fce();
            fce_period(p);
            chk(p == 4, "R6 clamp period", p, 4);
            chk(div_active == 6'd2, "R6 clamp value", div_active, 2);
        end

        // R4, R5: modulation clock at the floor value
        repeat (2) wait_mce();
        mce_period(p);
        chk(p == 160, "R4 mclk_ce period at 2", p, 160);
        msq_high(p);
        chk(p == 80, "R5 mclk_sq high at 2", p, 80);

        // R4: modulation clock at the largest value
        write_div(63);
        repeat (2) wait_mce();
        mce_period(p);
        chk(p == 80 * 63, "R4 mclk_ce period at 63", p, 80 * 63);

        // R7: a write partway through a period gives no third run length
        write_div(20);
        repeat (3) wait_fce();
        repeat (7) @(negedge clk);
        write_div(45);
        for (int k = 0; k < 6; k++) begin
            fsq_run(p);
            chk(p == 20 || p == 45, "R7 run length across a write", p, 45);
        end
        fsq_run(p);
        chk(p == 45, "R7 settled run length", p, 45);

        // R2, R3, R9: random values across the whole range
        for (int k = 0; k < 12; k++) begin
            v = int'($urandom % 64);
            n = exp_n(v);
            write_div(v);
            repeat (2) wait_fce();
            chk(div_active == 6'(n), "R9 active value", div_active, n);
            fce_period(p);
            chk(p == 2 * n, "R2 fclk_ce period", p, 2 * n);
            fsq_high(p);
            chk(p == n, "R3 fclk_sq high", p, n);
        end

        // R10: reset during operation restores the default
        write_div(7);
        repeat (2) wait_fce();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!fclk_ce && !fclk_sq && !mclk_ce && !mclk_sq, "R10 outputs cleared",
            {fclk_ce, fclk_sq, mclk_ce, mclk_sq}, 0);
        chk(div_active == 6'd31, "R10 value restored", div_active, 31);
        rst_n = 1'b1;
        fce_period(p);
        chk(p == 62, "R10 period after reset", p, 62);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule